// File: doc/BRIEF.md
# Output-Feedback Stream Cipher Wrapper

This block turns an iterative ARX block-cipher encryption core into a stream engine for messages of any number of blocks, using output-feedback (OFB) chaining. A single load handshake supplies the master key and an initialization vector. The key is written into the core, and the vector enters the core as its first block. Each block the core returns is keystream. It goes straight back into the core as the next block to encrypt, and it is XORed with one queued message block. The XOR result is placed in an output FIFO.

Encryption and decryption are the same operation. To recover plaintext, the user pulses `restart`, loads the same key and vector again, and feeds the ciphertext through. A session flag keeps key loading and keystream production apart. While the flag is clear, any keystream block still coming out of the core is discarded, so a stale stream can never mix with a new one.

The core runs one round per cycle. It computes round keys on the fly next to the data path and keeps only the master key and the current key-schedule words.

Top module: `ofb_wrap`

## Requirements
- R1: During and right after reset, `out_valid` is 0, `ld_ready` is 1 and `msg_ready` is 1.
- R2: The core uses 16-bit words, 4 key words and 22 rounds, with a right rotation of 7 and a left rotation of 2. The least significant key word is the first round key. The upper half of a block is the rotated word. With key 0x1918111009080100 and vector 0x6574694c, the first keystream block is 0xa86842f2, so a zero first message block produces that value.
- R3: Output block j equals message block j XOR E^(j+1)(IV), where E^(j+1) means j+1 chained encryptions under the loaded key.
- R4: `ld_ready` is 0 while a session is active. A load that is offered then has no effect, and the keystream continues unchanged.
- R5: The keystream advances only when a message block is available. Idle time before or between message blocks does not change any output value, and no output appears without a message block.
- R6: `restart` ends the session. Keystream from the old vector is discarded, and the next load starts from the new key and vector.
- R7: After `restart`, a reload of the same key and vector makes the ciphertext blocks come out as the original plaintext blocks.
- R8: `restart` discards message blocks that are queued but not yet used, and `msg_ready` is 0 in the cycle `restart` is high.
- R9: While `out_ready` is low, the output FIFO fills and message consumption stops. No block is lost or reordered when `out_ready` returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| restart | input | 1 | Ends the session and flushes queued message blocks |
| ld_valid | input | 1 | Key and vector load request |
| ld_ready | output | 1 | Load can be accepted |
| ld_key | input | 64 | Master key, least significant word first round key |
| ld_iv | input | 32 | Initialization vector |
| msg_valid | input | 1 | Message block offered |
| msg_ready | output | 1 | Message FIFO can accept a block |
| msg_data | input | 32 | Message block (plaintext or ciphertext) |
| out_valid | output | 1 | Result block available |
| out_ready | input | 1 | Consumer takes the result block |
| out_data | output | 32 | Result block |

## Verification
The bench compares every result with a cipher model computed in the bench from the stated round and key-schedule equations. A zero first block exposes the raw keystream against the known-answer value. All-ones, alternating, walking-bit and counter message patterns then show whether the XOR and the chaining are correct. Messages that arrive late or under output backpressure show whether the keystream ever advances or drops blocks without data. Restarts are tried in three situations: a full decrypt round trip, a restart with a keystream block still pending in the core, and a restart with message blocks still queued. These separate draining, flushing and session reload from one another. Several key and vector pairs are swept through encrypt and decrypt.

// File: rtl/ofb_pkg.sv
// Shared types for the OFB wrapper and its cipher core.
package ofb_pkg;
    // Sequencing states of the iterative cipher core.
    typedef enum logic [1:0] {
        CORE_IDLE = 2'd0,
        CORE_RUN  = 2'd1,
        CORE_DONE = 2'd2
    } core_st_e;
endpackage

// File: rtl/arx_round.sv
// One ARX round: rotate right, add, XOR key; then rotate left, XOR.
// Assumes 0 < RA < W and 0 < RB < W. Purely combinational.
module arx_round #(
    parameter int W  = 16,
    parameter int RA = 7,
    parameter int RB = 2
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic [W-1:0] k_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] b_out
);
    logic [W-1:0] a_rot;
    logic [W-1:0] b_rot;

    // rotations and mixing
    always_comb begin
        a_rot = (a_in >> RA) | (a_in << (W - RA));
        b_rot = (b_in << RB) | (b_in >> (W - RB));
        a_out = (a_rot + b_in) ^ k_in;
        b_out = b_rot ^ a_out;
    end
endmodule

// File: rtl/sync_fifo.sv
// Synchronous FIFO with a flush input. Assumes DEPTH is a power of two,
// and that the user never pushes when full or pops when empty.
module sync_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic          full,
    output logic          empty
);
    localparam int AW = $clog2(DEPTH);

    logic [DW-1:0] mem_q [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [AW:0]   cnt_q;

    assign full  = (cnt_q == (AW+1)'(DEPTH));
    assign empty = (cnt_q == '0);
    assign dout  = mem_q[rp_q];

    // storage write
    always_ff @(posedge clk) begin
        if (push) mem_q[wp_q] <= din;
    end

    // pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wp_q <= wp_q + 1'b1;
            if (pop)  rp_q <= rp_q + 1'b1;
            cnt_q <= cnt_q + (AW+1)'(push) - (AW+1)'(pop);
        end
    end

    // R9
    fifo_push_chk: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);
    // R9
    fifo_pop_chk: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);
endmodule

// File: rtl/arx_core.sv
// Iterative ARX block cipher, encryption only, one round per cycle.
// The round keys are generated on the fly by a second round instance.
// The master key is held so that every block restarts the schedule.
// A block is accepted in IDLE, or in DONE when its result is taken in
// the same cycle. A key write is allowed only together with or before
// a start while idle; a key written with a start is used at once.
module arx_core
    import ofb_pkg::*;
#(
    parameter int W  = 16,
    parameter int M  = 4,
    parameter int T  = 22,
    parameter int RA = 7,
    parameter int RB = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           key_we,
    input  logic [M*W-1:0] key,
    input  logic           in_valid,
    output logic           in_ready,
    input  logic [2*W-1:0] in_blk,
    output logic           res_valid,
    input  logic           res_ready,
    output logic [2*W-1:0] res_blk
);
    localparam int BW = 2 * W;
    localparam int RW = $clog2(T);
    localparam int LN = M - 1;

    core_st_e       st_q;
    logic [RW-1:0]  rnd_q;
    logic [W-1:0]   x_q, y_q, k_q;
    logic [W-1:0]   l_q [LN];
    logic [M*W-1:0] key_q;

    logic [M*W-1:0] key_src;
    logic [W-1:0]   x_nx, y_nx, l_nx, k_nx;
    logic           start;

    assign in_ready  = (st_q == CORE_IDLE) || (st_q == CORE_DONE && res_ready);
    assign res_valid = (st_q == CORE_DONE);
    assign res_blk   = {x_q, y_q};
    assign start     = in_valid && in_ready;
    assign key_src   = key_we ? key : key_q;

    arx_round #(.W(W), .RA(RA), .RB(RB)) u_data (
        .a_in(x_q), .b_in(y_q), .k_in(k_q), .a_out(x_nx), .b_out(y_nx)
    );

    arx_round #(.W(W), .RA(RA), .RB(RB)) u_sched (
        .a_in(l_q[0]), .b_in(k_q), .k_in(W'(rnd_q)), .a_out(l_nx), .b_out(k_nx)
    );

    // master key holding register
    always_ff @(posedge clk) begin
        if (!rst_n)      key_q <= '0;
        else if (key_we) key_q <= key;
    end

    // round sequencing, data and key-schedule state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= CORE_IDLE;
            rnd_q <= '0;
            x_q   <= '0;
            y_q   <= '0;
            k_q   <= '0;
            for (int j = 0; j < LN; j++) l_q[j] <= '0;
        end else if (start) begin
            st_q  <= CORE_RUN;
            rnd_q <= '0;
            x_q   <= in_blk[BW-1:W];
            y_q   <= in_blk[W-1:0];
            k_q   <= key_src[W-1:0];
            for (int j = 0; j < LN; j++) l_q[j] <= key_src[(j+1)*W +: W];
        end else if (st_q == CORE_RUN) begin
            x_q   <= x_nx;
            y_q   <= y_nx;
            k_q   <= k_nx;
            for (int j = 0; j < LN - 1; j++) l_q[j] <= l_q[j+1];
            l_q[LN-1] <= l_nx;
            rnd_q <= rnd_q + 1'b1;
            if (rnd_q == RW'(T - 1)) st_q <= CORE_DONE;
        end else if (st_q == CORE_DONE && res_ready) begin
            st_q <= CORE_IDLE;
        end
    end

    // R4
    core_key_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_we |-> (st_q == CORE_IDLE));
    // R2
    core_rnd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CORE_RUN) |-> (rnd_q < RW'(T)));
    // R5
    core_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_blk)));
endmodule

// File: rtl/ofb_wrap.sv
// OFB session controller around one ARX encryption core.
// A load puts the key into the core and sends the vector as its first
// block. Every core result is returned to the core and XORed with one
// queued message block, but only when a message block is waiting and
// the output FIFO has room. restart clears the session and flushes the
// message FIFO. While no session is active, core results are dropped.
module ofb_wrap
    import ofb_pkg::*;
#(
    parameter int W         = 16,
    parameter int M         = 4,
    parameter int T         = 22,
    parameter int RA        = 7,
    parameter int RB        = 2,
    parameter int MSG_DEPTH = 4,
    parameter int OUT_DEPTH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           restart,
    input  logic           ld_valid,
    output logic           ld_ready,
    input  logic [M*W-1:0] ld_key,
    input  logic [2*W-1:0] ld_iv,
    input  logic           msg_valid,
    output logic           msg_ready,
    input  logic [2*W-1:0] msg_data,
    output logic           out_valid,
    input  logic           out_ready,
    output logic [2*W-1:0] out_data
);
    localparam int BW = 2 * W;

    logic          started_q;
    logic          c_in_valid, c_in_ready, c_res_valid, c_res_ready;
    logic [BW-1:0] c_in_blk, c_res_blk;
    logic          m_full, m_empty, o_full, o_empty;
    logic [BW-1:0] m_dout;
    logic          ld_fire, ks_fire, core_idle;

    // handshake and keystream-step decisions
    always_comb begin
        core_idle   = c_in_ready && !c_res_valid;
        ld_ready    = !started_q && core_idle && !restart;
        ld_fire     = ld_valid && ld_ready;
        ks_fire     = started_q && !restart && c_res_valid && !m_empty && !o_full;
        c_res_ready = ks_fire || !started_q;
        c_in_valid  = ks_fire || ld_fire;
        c_in_blk    = ld_fire ? ld_iv : c_res_blk;
        msg_ready   = !m_full && !restart;
        out_valid   = !o_empty;
    end

    // session flag
    always_ff @(posedge clk) begin
        if (!rst_n || restart) started_q <= 1'b0;
        else if (ld_fire)      started_q <= 1'b1;
    end

    arx_core #(.W(W), .M(M), .T(T), .RA(RA), .RB(RB)) u_core (
        .clk(clk), .rst_n(rst_n),
        .key_we(ld_fire), .key(ld_key),
        .in_valid(c_in_valid), .in_ready(c_in_ready), .in_blk(c_in_blk),
        .res_valid(c_res_valid), .res_ready(c_res_ready), .res_blk(c_res_blk)
    );

    sync_fifo #(.DW(BW), .DEPTH(MSG_DEPTH)) u_msg_q (
        .clk(clk), .rst_n(rst_n), .flush(restart),
        .push(msg_valid && msg_ready), .din(msg_data),
        .pop(ks_fire), .dout(m_dout), .full(m_full), .empty(m_empty)
    );

    sync_fifo #(.DW(BW), .DEPTH(OUT_DEPTH)) u_out_q (
        .clk(clk), .rst_n(rst_n), .flush(1'b0),
        .push(ks_fire), .din(c_res_blk ^ m_dout),
        .pop(out_valid && out_ready), .dout(out_data), .full(o_full), .empty(o_empty)
    );

    // R4
    ld_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_fire |=> started_q);
    // R6
    restart_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !started_q);
    // R3
    core_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_in_valid |-> c_in_ready);
    // R5
    ks_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && c_res_valid && m_empty) |=> c_res_valid);
endmodule

// File: tb/sim_ofb_wrap.sv
module sim_ofb_wrap;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        restart = 1'b0;
    logic        ld_valid = 1'b0;
    logic        ld_ready;
    logic [63:0] ld_key = '0;
    logic [31:0] ld_iv = '0;
    logic        msg_valid = 1'b0;
    logic        msg_ready;
    logic [31:0] msg_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;

    int total = 0;
    int bad = 0;
    bit hold = 1'b0;
    logic [31:0] got[$];
    logic [31:0] pq[$];
    logic [31:0] cq[$];
    logic [63:0] cur_key;
    logic [31:0] ks;

    always #5 clk = ~clk;

    ofb_wrap u0 (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_key(ld_key), .ld_iv(ld_iv),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_data(msg_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    function automatic logic [15:0] ror7(input logic [15:0] v);
        return {v[6:0], v[15:7]};
    endfunction

    function automatic logic [15:0] rol2(input logic [15:0] v);
        return {v[13:0], v[15:14]};
    endfunction

    function automatic logic [31:0] enc(input logic [63:0] key, input logic [31:0] pt);
        logic [15:0] x, y, k, nl;
        logic [15:0] l [3];
        x = pt[31:16]; y = pt[15:0]; k = key[15:0];
        l[0] = key[31:16]; l[1] = key[47:32]; l[2] = key[63:48];
        for (int i = 0; i < 22; i++) begin
            x = (ror7(x) + y) ^ k;
            y = rol2(y) ^ x;
            nl = (ror7(l[0]) + k) ^ 16'(i);
            k = rol2(k) ^ nl;
            l[0] = l[1]; l[1] = l[2]; l[2] = nl;
        end
        return {x, y};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // output collector, decides out_ready at the falling edge
    always @(negedge clk) begin
        out_ready = !hold;
        if (out_valid && !hold) got.push_back(out_data);
    end

    task automatic load(input logic [63:0] k, input logic [31:0] iv);
        ld_key = k; ld_iv = iv; ld_valid = 1'b1;
        while (!ld_ready) @(negedge clk);
        @(negedge clk);
        ld_valid = 1'b0;
        cur_key = k; ks = iv;
    endtask

    task automatic send(input logic [31:0] m);
        msg_data = m; msg_valid = 1'b1;
        while (!msg_ready) @(negedge clk);
        @(negedge clk);
        msg_valid = 1'b0;
    endtask

    task automatic pulse_restart();
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
    endtask

    task automatic wait_out(input int n);
        while (got.size() < n) @(negedge clk);
    endtask

    function automatic logic [31:0] pat(input int p);
        case (p % 5)
            0: return 32'h0000_0000;
            1: return 32'hffff_ffff;
            2: return 32'haaaa_5555;
            3: return 32'h1 << p;
            default: return 32'h0101_0101 * p;
        endcase
    endfunction

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=%h exp=%h", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] e, m;
        int base;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 0);
        chk(ld_ready == 1'b1, "R1 ld_ready", 32'(ld_ready), 1);
        chk(msg_ready == 1'b1, "R1 msg_ready", 32'(msg_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 no output before any message, R2 known answer
        load(64'h1918_1110_0908_0100, 32'h6574_694c);
        repeat (100) @(negedge clk);
        chk(got.size() == 0 && !out_valid, "R5 idle", 32'(got.size()), 0);
        send(32'h0);
        wait_out(1);
        chk(got[0] == 32'ha868_42f2, "R2 kat", got[0], 32'ha868_42f2);
        ks = enc(cur_key, ks);
        pq.push_back(32'h0); cq.push_back(got[0]);

        // R3 chained blocks over several patterns, with gaps (R5)
        for (int p = 1; p < 9; p++) begin
            m = pat(p);
            send(m);
            if (p % 3 == 0) repeat (40) @(negedge clk);
            wait_out(p + 1);
            ks = enc(cur_key, ks);
            e = ks ^ m;
            chk(got[p] == e, (p % 3 == 0) ? "R5 gap" : "R3 chain", got[p], e);
            pq.push_back(m); cq.push_back(got[p]);
        end

        // R4 load offered during a session is ignored
        chk(ld_ready == 1'b0, "R4 ld_ready", 32'(ld_ready), 0);
        ld_key = 64'hdead_beef_0000_1111; ld_iv = 32'h1234_5678; ld_valid = 1'b1;
        repeat (5) @(negedge clk);
        ld_valid = 1'b0;
        m = 32'h0f0f_f0f0;
        send(m);
        wait_out(10);
        ks = enc(cur_key, ks);
        chk(got[9] == (ks ^ m), "R4 stream kept", got[9], ks ^ m);
        pq.push_back(m); cq.push_back(got[9]);

        // R9 backpressure: fill both FIFOs, then release
        hold = 1'b1;
        base = got.size();
        for (int p = 0; p < 8; p++) send(32'h5a00_0000 + 32'(p * 77));
        repeat (300) @(negedge clk);
        chk(got.size() == base, "R9 held", 32'(got.size()), 32'(base));
        chk(out_valid == 1'b1, "R9 out_valid", 32'(out_valid), 1);
        hold = 1'b0;
        wait_out(base + 8);
        for (int p = 0; p < 8; p++) begin
            m = 32'h5a00_0000 + 32'(p * 77);
            ks = enc(cur_key, ks);
            chk(got[base + p] == (ks ^ m), "R9 order", got[base + p], ks ^ m);
            pq.push_back(m); cq.push_back(got[base + p]);
        end

        // R7 decrypt round trip with the same key and vector
        pulse_restart();
        load(64'h1918_1110_0908_0100, 32'h6574_694c);
        base = got.size();
        foreach (cq[i]) send(cq[i]);
        wait_out(base + cq.size());
        foreach (pq[i]) chk(got[base + i] == pq[i], "R7 decrypt", got[base + i], pq[i]);
        // core now holds a pending keystream block

        // R6 restart drops stale keystream, new session starts fresh
        pulse_restart();
        load(64'h0011_2233_4455_6677, 32'h89ab_cdef);
        base = got.size();
        m = 32'hc3c3_3c3c;
        send(m);
        wait_out(base + 1);
        e = enc(64'h0011_2233_4455_6677, 32'h89ab_cdef) ^ m;
        chk(got[base] == e, "R6 new iv", got[base], e);

        // R8 restart flushes queued message blocks
        pulse_restart();
        send(32'h1111_1111);
        send(32'h2222_2222);
        pulse_restart();
        load(64'h0011_2233_4455_6677, 32'h0bad_f00d);
        base = got.size();
        m = 32'h7777_0000;
        send(m);
        wait_out(base + 1);
        repeat (100) @(negedge clk);
        chk(got.size() == base + 1, "R8 count", 32'(got.size()), 32'(base + 1));
        e = enc(64'h0011_2233_4455_6677, 32'h0bad_f00d) ^ m;
        chk(got[base] == e, "R8 first", got[base], e);
        // R8 msg_ready low while restart is high
        restart = 1'b1;
        #1;
        chk(msg_ready == 1'b0, "R8 msg_ready", 32'(msg_ready), 0);
        @(negedge clk);
        restart = 1'b0;

        // R3 R7 sweep over keys and vectors: encrypt then decrypt
        for (int s = 0; s < 3; s++) begin
            logic [63:0] k;
            logic [31:0] iv;
            logic [31:0] sp[6];
            logic [31:0] sc[6];
            k = 64'h0123_4567_89ab_cdef ^ (64'(s) * 64'h1111_2222_3333_4444);
            iv = 32'hfeed_0000 + 32'(s * 1000);
            load(k, iv);
            base = got.size();
            for (int p = 0; p < 6; p++) begin
                sp[p] = pat(p + s) ^ 32'(s);
                send(sp[p]);
            end
            wait_out(base + 6);
            for (int p = 0; p < 6; p++) begin
                ks = enc(k, ks);
                sc[p] = got[base + p];
                chk(sc[p] == (ks ^ sp[p]), "R3 sweep enc", sc[p], ks ^ sp[p]);
            end
            pulse_restart();
            load(k, iv);
            base = got.size();
            for (int p = 0; p < 6; p++) send(sc[p]);
            wait_out(base + 6);
            for (int p = 0; p < 6; p++)
                chk(got[base + p] == sp[p], "R7 sweep dec", got[base + p], sp[p]);
            pulse_restart();
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule